// File: doc/BRIEF.md
# Collision Vector Initiation Controller

This block decides, cycle by cycle, whether a new task may enter a multi-function pipeline whose conflicts are summarised by a collision vector. A vector bit set at position i-1 says that a second task started i cycles after a first one would meet it in some stage, so that spacing is forbidden. The controller keeps a shift register of forbidden offsets measured from the present cycle. It raises `allow_o` when the present cycle is free, and it grants a request only in a free cycle. Each grant merges the collision vector into the shifted state.

A latency output gives the number of cycles since the last accepted task, so the spacing between initiations can be read beside each grant. Two scheduling modes exist. In strict mode a request counts only in its own cycle and is dropped if that cycle is forbidden. In greedy mode a request is held until the first free cycle, which follows the minimum-latency edges of the pipeline's state diagram.

Top module: `cvic_ctrl`

## Requirements
- R1: `grant_o` is never high in a cycle where bit 0 of `state_o` is set; `allow_o` is high exactly when bit 0 of `state_o` is clear.
- R2: After reset `state_o` is all zeros, `latency_o` reads CV_W+1 and no request is pending.
- R3: After a grant, the next `state_o` is the current state shifted right by one with zero fill, ORed with `cv_i` (bit i-1 of `cv_i` set means latency i is forbidden).
- R4: In a cycle without a grant, the next `state_o` is the current state shifted right by one with a zero in the top bit.
- R5: In any cycle `latency_o` equals the number of cycles since the most recent grant, so it reads 1 the cycle after a grant, and it saturates at CV_W+1 (also before the first grant).
- R6: With `greedy_i` high, a request is held pending and is granted in the first cycle in which `allow_o` is high, including its own cycle.
- R7: With `greedy_i` low, a request is granted only in its own cycle and only when `allow_o` is high; a refused request is forgotten.
- R8: With vector 7'b1011010 and a request held high in greedy mode, the spacing between grants alternates 1, 8, 1, 8.
- R9: With vector 7'b1011010, requests every 3 cycles in strict mode are all granted.
- R10: A spacing of CV_W+1 cycles is always granted, even for an all-ones vector, whose greedy schedule is a constant CV_W+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cv_i | input | CV_W | Collision vector; bit i-1 set forbids latency i |
| greedy_i | input | 1 | 1 = hold requests until the first free cycle, 0 = strict |
| req_i | input | 1 | Request to start a task |
| grant_o | output | 1 | Task start accepted this cycle |
| allow_o | output | 1 | A start would be legal this cycle |
| state_o | output | CV_W | Forbidden-offset shift register, bit 0 = present cycle |
| latency_o | output | LAT_W | Cycles since the last grant, saturating at CV_W+1 |

## Verification
A request held high in greedy mode on vector 1011010 must give the greedy cycle (1, 8) and not the constant cycle 3, which shows that the earliest free slot is taken. Strict requests spaced by 3 show that a permissible constant cycle is never blocked. A strict request at forbidden latency 2 shows that refused requests are dropped, while the same pulse in greedy mode must be granted at latency 3. All-ones and all-zeros vectors mark the two ends: every start spaced CV_W+1 apart in one case, and a start in every cycle in the other. Each cycle is compared with a model that derives forbidden slots from the history of grant times.

// File: rtl/cvic_pkg.sv
`timescale 1ns/1ps
package cvic_pkg;
  typedef enum logic {
    MODE_STRICT = 1'b0,
    MODE_GREEDY = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/cvic_state_reg.sv
`timescale 1ns/1ps
module cvic_state_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cv_i,
  input  logic         fire_i,
  output logic [W-1:0] state_o,
  output logic         free_o
);
  logic [W-1:0] st_q;

  // Advance one cycle: drop the present slot; merge the vector on a start.
  function automatic logic [W-1:0] advance(input logic [W-1:0] st,
                                           input logic [W-1:0] cv,
                                           input logic fire);
    logic [W-1:0] sh;
    sh = st >> 1;
    return fire ? (sh | cv) : sh;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= advance(st_q, cv_i, fire_i);
  end

  assign state_o = st_q;
  assign free_o  = ~st_q[0];
endmodule

// File: rtl/cvic_latency_ctr.sv
`timescale 1ns/1ps
module cvic_latency_ctr #(
  parameter int W  = 7,
  parameter int LW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  output logic [LW-1:0] lat_o
);
  localparam logic [LW-1:0] LAT_MAX = LW'(W + 1);
  logic [LW-1:0] cnt_q;

  function automatic logic [LW-1:0] tick(input logic [LW-1:0] c,
                                         input logic fire);
    if (fire)          return LW'(1);
    if (c >= LAT_MAX)  return LAT_MAX;
    return c + LW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= LAT_MAX;
    else        cnt_q <= tick(cnt_q, fire_i);
  end

  assign lat_o = cnt_q;
endmodule

// File: rtl/cvic_admit.sv
`timescale 1ns/1ps
module cvic_admit
  import cvic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  sched_mode_e mode_i,
  input  logic        req_i,
  input  logic        free_i,
  output logic        fire_o,
  output logic        pend_o
);
  logic pend_q;
  logic want;

  always_comb begin
    want   = req_i | ((mode_i == MODE_GREEDY) & pend_q);
    fire_o = want & free_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (mode_i == MODE_GREEDY) & want & ~fire_o;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cvic_ctrl.sv
`timescale 1ns/1ps
module cvic_ctrl
  import cvic_pkg::*;
#(
  parameter int CV_W  = 7,
  parameter int LAT_W = $clog2(CV_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CV_W-1:0]  cv_i,
  input  logic             greedy_i,
  input  logic             req_i,
  output logic             grant_o,
  output logic             allow_o,
  output logic [CV_W-1:0]  state_o,
  output logic [LAT_W-1:0] latency_o
);
  sched_mode_e mode_w;
  logic        free_w;
  logic        fire_w;
  logic        pend_w;

  assign mode_w = greedy_i ? MODE_GREEDY : MODE_STRICT;

  cvic_state_reg #(.W(CV_W)) u_state (
    .clk(clk), .rst_n(rst_n), .cv_i(cv_i), .fire_i(fire_w),
    .state_o(state_o), .free_o(free_w)
  );

  cvic_admit u_admit (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w), .req_i(req_i),
    .free_i(free_w), .fire_o(fire_w), .pend_o(pend_w)
  );

  cvic_latency_ctr #(.W(CV_W), .LW(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_w), .lat_o(latency_o)
  );

  assign grant_o = fire_w;
  assign allow_o = free_w;
endmodule

// File: rtl/cvic_ctrl_chk.sv
`timescale 1ns/1ps
module cvic_ctrl_chk #(
  parameter int W  = 7,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  cv_i,
  input logic          greedy_i,
  input logic          req_i,
  input logic          grant_o,
  input logic          allow_o,
  input logic [W-1:0]  state_o,
  input logic [LW-1:0] latency_o,
  input logic          pend_w
);
  assert_no_collision_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (!state_o[0] && allow_o));

  assert_merge_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> ((state_o & $past(cv_i)) == $past(cv_i)));

  assert_idle_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_o |=> (state_o == ($past(state_o) >> 1)));

  assert_latency_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> (latency_o == LW'(1)));

  assert_greedy_takes_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (greedy_i && (pend_w || req_i) && allow_o) |-> grant_o);

  assert_strict_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!greedy_i && grant_o) |-> req_i);
endmodule

bind cvic_ctrl cvic_ctrl_chk #(.W(CV_W), .LW(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cv_i(cv_i), .greedy_i(greedy_i), .req_i(req_i),
  .grant_o(grant_o), .allow_o(allow_o), .state_o(state_o),
  .latency_o(latency_o), .pend_w(pend_w)
);

// File: tb/cvic_ctrl_tb.sv
`timescale 1ns/1ps
module cvic_ctrl_tb;
  localparam int W    = 7;
  localparam int LW   = $clog2(W + 2);
  localparam int LMAX = W + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  cv = 7'b1011010;
  logic          greedy = 1'b0;
  logic          req = 1'b0;
  logic          grant, allow;
  logic [W-1:0]  state;
  logic [LW-1:0] latency;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int cyc = 0;
  int gq[$];      // model: cycles in which a start was accepted
  int lat_q[$];   // latencies observed at grants
  bit pend_m = 0;

  always #2.5 clk = ~clk;

  cvic_ctrl #(.CV_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cv_i(cv), .greedy_i(greedy), .req_i(req),
    .grant_o(grant), .allow_o(allow), .state_o(state), .latency_o(latency)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Forbidden slots of the present cycle, derived from all earlier starts.
  function automatic logic [W-1:0] model_state();
    logic [W-1:0] s = '0;
    foreach (gq[k]) begin
      int d = cyc - gq[k];
      for (int j = 0; j < W; j++)
        if (d >= 1 && j + d - 1 < W && cv[j + d - 1]) s[j] = 1'b1;
    end
    return s;
  endfunction

  task automatic step(input logic r);
    logic [W-1:0] es;
    bit ea, eg;
    int el;
    @(negedge clk);
    req = r;
    #1;
    es = model_state();
    ea = !es[0];
    eg = ea && (r || (greedy && pend_m));
    if (gq.size() == 0) el = LMAX;
    else el = (cyc - gq[$] >= LMAX) ? LMAX : cyc - gq[$];
    chk(state == es, "R3/R4 state", int'(state), int'(es));
    chk(allow == ea, "R1 allow", int'(allow), int'(ea));
    chk(grant == eg, greedy ? "R6 grant" : "R7 grant", int'(grant), int'(eg));
    chk(int'(latency) == el, "R5 latency", int'(latency), el);
    if (grant) lat_q.push_back(int'(latency));
    if (eg) gq.push_back(cyc);
    pend_m = greedy && (r || pend_m) && !eg;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2: reset state
    chk(state == '0, "R2 state", int'(state), 0);
    chk(int'(latency) == LMAX, "R2 latency", int'(latency), LMAX);
    chk(grant == 1'b0, "R2 grant", int'(grant), 0);

    // R8: greedy, held request, vector 1011010
    greedy = 1'b1; lat_q.delete();
    for (int i = 0; i < 30; i++) step(1'b1);
    chk(lat_q.size() >= 5, "R8 count", lat_q.size(), 5);
    if (lat_q.size() >= 5) begin
      chk(lat_q[1] == 1, "R8 lat1", lat_q[1], 1);
      chk(lat_q[2] == 8, "R8 lat2", lat_q[2], 8);
      chk(lat_q[3] == 1, "R8 lat3", lat_q[3], 1);
      chk(lat_q[4] == 8, "R8 lat4", lat_q[4], 8);
    end
    idle(12);

    // R9: strict constant spacing 3
    greedy = 1'b0; lat_q.delete();
    for (int i = 0; i < 8; i++) begin step(1'b1); step(1'b0); step(1'b0); end
    chk(lat_q.size() == 8, "R9 grants", lat_q.size(), 8);
    for (int i = 1; i < lat_q.size(); i++) chk(lat_q[i] == 3, "R9 spacing", lat_q[i], 3);
    idle(12);

    // R7: strict request at forbidden latency 2 is dropped
    lat_q.delete();
    step(1'b1); step(1'b0); step(1'b1); idle(10);
    chk(lat_q.size() == 1, "R7 dropped", lat_q.size(), 1);
    idle(4);

    // R6: same pulse in greedy mode waits for latency 3
    greedy = 1'b1; lat_q.delete();
    step(1'b1); step(1'b0); step(1'b1); idle(10);
    chk(lat_q.size() == 2, "R6 held", lat_q.size(), 2);
    if (lat_q.size() == 2) chk(lat_q[1] == 3, "R6 latency", lat_q[1], 3);
    idle(4);

    // R10: all-ones vector, greedy gives constant CV_W+1
    cv = '1; lat_q.delete();
    for (int i = 0; i < 40; i++) step(1'b1);
    chk(lat_q.size() >= 4, "R10 count", lat_q.size(), 4);
    foreach (lat_q[k]) chk(lat_q[k] == LMAX, "R10 spacing", lat_q[k], LMAX);
    idle(12);

    // all-zeros vector: a start in every cycle (R1, R7)
    cv = '0; greedy = 1'b0; lat_q.delete();
    for (int i = 0; i < 10; i++) step(1'b1);
    chk(lat_q.size() == 10, "R7 every cycle", lat_q.size(), 10);
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule